// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block is a synthesizable behavioural model of a parallel NOR flash device. The host sees one address bus, a write strobe with write data, and a combinational read-data bus. After reset the device is in array-read mode, and a read returns the stored bytes at the address. A write made while the device is idle is a command. The command byte selects one of these operations: single program, sector erase, status read, status clear, lock/unlock, query, or buffered write. The device then reads some of the following writes as arguments. These are a confirm code, a word count, or data words.

The backing store is a small on-chip byte array that holds all ones after reset. A bus word is `BUS_BYTES` bytes wide (1, 2 or 4). The parameter `BIG_END` sets how the bytes of a word map onto the array. The default is little-endian: the byte at the lowest address sits in bits 7:0. The query table is a constant ROM computed from the geometry parameters. Timing delays, erase suspend and multi-sector erase are not modelled. Lock commands are accepted but do not protect any data.

Top module: `nce_top`

## Requirements
- R1: After synchronous reset, every array byte is 0xFF, the status register is 0x00, and the device is in array-read mode.
- R2: In array-read mode, `rd_data` returns the `BUS_BYTES` bytes that start at `addr`. With the default byte order, the byte at `addr` appears in bits 7:0 and the byte at `addr+1` in bits 15:8.
- R3: An idle write of 0x10 or 0x40, followed by a data write, stores that word at the data write's address and sets status bit 7. After this, reads return the status register until another command is written.
- R4: An idle write of 0x20 sets every byte of the aligned `SECTOR_BYTES` sector that contains the address to 0xFF, and sets status bit 7. The next write must be 0xD0, which confirms the erase, sets ready and leaves reads returning status. A write of 0xFF or any other value instead returns the device to array-read mode. No other sector changes.
- R5: An idle write of 0x70 selects status read. Reads then return the 8-bit status register zero-extended, with the ready flag in bit 7. The next write is decoded as a new command.
- R6: An idle write of 0x50 sets the status register to 0x00 and returns the device to array-read mode.
- R7: An idle write of 0x60, followed by 0xD0 or 0x01, leaves the device returning status with bit 7 set. Any other second write returns the device to array-read mode. Array contents never change.
- R8: An idle write of 0x98 enters query mode. Reads then return the table byte at index `addr[7:0] >> log2(BUS_BYTES)`, zero-extended. Indices 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59. Any index of 0x40 or above reads 0. Query mode persists through any write other than 0xFF, which returns the device to array-read mode.
- R9: An idle write of 0xE8 starts a buffered write. The next write gives a count N, the following N+1 writes each store one word at their own address, and then a confirm write follows. A confirm of 0xD0 sets ready and leaves reads returning status. Any other confirm value returns the device to array-read mode, and the stored words are kept.
- R10: An idle write of 0x00, 0xFF or any byte that is not a command returns the device to array-read mode and changes neither the array nor the status register.
- R11: Query index 0x27 holds log2 of the array size in bytes. Index 0x2A holds the log2 of the largest write buffer in bytes: 8 for a one-byte bus, 11 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | log2(ARRAY_BYTES) | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| wr_data | input | 8*BUS_BYTES | Write data; bits 7:0 carry command codes |
| rd_data | output | 8*BUS_BYTES | Read data for the current mode and address |

## Verification
Each write is applied at the rising edge where `wr_en` is high. Its effect on the mode, the status register and the array therefore appears on `rd_data` in the very next cycle, and reads are combinational on `addr` within a cycle. The bench drives every input just after a falling edge, and it updates its behavioural model once that write's rising edge has passed. It then moves `addr` and compares `rd_data` a nanosecond later, well before the next rising edge. As a result each comparison sees exactly the state that the writes issued so far should have produced.

// File: rtl/nce_pkg.sv
package nce_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARG     = 2'd1,
        PH_DATA    = 2'd2,
        PH_CONFIRM = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_STATUS = 2'd1,
        RD_QUERY  = 2'd2
    } rd_sel_e;

    typedef struct packed {
        phase_e     ph;
        logic [7:0] op;
    } ctl_t;

    localparam logic [7:0] OP_NONE   = 8'h00;
    localparam logic [7:0] OP_PROG_A = 8'h10;
    localparam logic [7:0] OP_PROG_B = 8'h40;
    localparam logic [7:0] OP_ERASE  = 8'h20;
    localparam logic [7:0] OP_CLR    = 8'h50;
    localparam logic [7:0] OP_LOCK   = 8'h60;
    localparam logic [7:0] OP_STAT   = 8'h70;
    localparam logic [7:0] OP_QUERY  = 8'h98;
    localparam logic [7:0] OP_BUF    = 8'hE8;
    localparam logic [7:0] OP_ARRAY  = 8'hFF;
    localparam logic [7:0] CODE_GO   = 8'hD0;
    localparam logic [7:0] CODE_LOCK = 8'h01;

    localparam ctl_t CTL_ARRAY = '{ph: PH_IDLE, op: OP_NONE};

    function automatic logic is_opcode(input logic [7:0] c);
        return (c == OP_PROG_A) || (c == OP_PROG_B) || (c == OP_ERASE) ||
               (c == OP_CLR) || (c == OP_LOCK) || (c == OP_STAT) ||
               (c == OP_QUERY) || (c == OP_BUF);
    endfunction

    function automatic logic [7:0] query_entry(input logic [7:0] idx,
                                               input int total_bytes,
                                               input int bus_bytes,
                                               input int sector_bytes);
        int nblk;
        logic [7:0] r;
        nblk = total_bytes / sector_bytes;
        r = 8'h00;
        case (idx)
            8'h10: r = 8'h51;
            8'h11: r = 8'h52;
            8'h12: r = 8'h59;
            8'h13: r = 8'h01;
            8'h15: r = 8'h31;
            8'h1B: r = 8'h45;
            8'h1C: r = 8'h55;
            8'h1F: r = 8'h07;
            8'h20: r = 8'h07;
            8'h21: r = 8'h0A;
            8'h23: r = 8'h04;
            8'h24: r = 8'h04;
            8'h25: r = 8'h04;
            8'h27: r = 8'($clog2(total_bytes));
            8'h28: r = 8'h02;
            8'h2A: r = (bus_bytes == 1) ? 8'd8 : 8'd11;
            8'h2C: r = 8'h01;
            8'h2D: r = 8'(nblk - 1);
            8'h2E: r = 8'((nblk - 1) >> 8);
            8'h2F: r = 8'(sector_bytes >> 8);
            8'h30: r = 8'(sector_bytes >> 16);
            8'h31: r = 8'h50;
            8'h32: r = 8'h52;
            8'h33: r = 8'h49;
            8'h34: r = 8'h31;
            8'h35: r = 8'h31;
            default: r = 8'h00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nce_array.sv
module nce_array #(
    parameter int ARRAY_BYTES  = 256,
    parameter int SECTOR_BYTES = 64,
    parameter int BUS_BYTES    = 2,
    parameter bit BIG_END      = 1'b0,
    localparam int AW = $clog2(ARRAY_BYTES),
    localparam int DW = 8 * BUS_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          prog_en,
    input  logic          erase_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int SW = $clog2(SECTOR_BYTES);

    logic [7:0]    mem     [ARRAY_BYTES];
    logic [7:0]    wr_byte [BUS_BYTES];
    logic [AW-1:0] lane_a  [BUS_BYTES];

    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
        localparam int LANE = BIG_END ? (BUS_BYTES - 1 - k) : k;
        assign lane_a[k]          = addr + AW'(k);
        assign wr_byte[k]         = wdata[8*LANE +: 8];
        assign rdata[8*LANE +: 8] = mem[lane_a[k]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < ARRAY_BYTES; i++)
                if ((AW'(i) >> SW) == (addr >> SW)) mem[i] <= 8'hFF;
        end else if (prog_en) begin
            for (int k = 0; k < BUS_BYTES; k++) mem[lane_a[k]] <= wr_byte[k];
        end
    end

    a_r4_erase_alone: assert property (@(posedge clk) disable iff (rst)
        !(erase_en && prog_en));

endmodule

// File: rtl/nce_query_rom.sv
module nce_query_rom #(
    parameter int ARRAY_BYTES  = 256,
    parameter int SECTOR_BYTES = 64,
    parameter int BUS_BYTES    = 2,
    parameter int QUERY_LEN    = 64
) (
    input  logic [7:0] raw_idx,
    output logic [7:0] qbyte
);
    import nce_pkg::*;
    localparam int QSHIFT = $clog2(BUS_BYTES);

    logic [7:0] idx;
    assign idx   = raw_idx >> QSHIFT;
    assign qbyte = (int'(idx) >= QUERY_LEN) ? 8'h00 :
                   query_entry(idx, ARRAY_BYTES, BUS_BYTES, SECTOR_BYTES);
endmodule

// File: rtl/nce_seq.sv
module nce_seq #(
    parameter int BUS_BYTES = 2,
    parameter int CNT_W     = 12,
    localparam int DW = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output nce_pkg::rd_sel_e  rd_sel,
    output logic              prog_en,
    output logic              erase_en,
    output logic [7:0]        status
);
    import nce_pkg::*;

    ctl_t             cur, nxt;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [7:0]       stat_n;
    logic [7:0]       wd;

    assign wd = wr_data[7:0];

    always_comb begin
        nxt      = cur;
        cnt_n    = cnt;
        stat_n   = status;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        if (wr_en) begin
            case (cur.ph)
                PH_IDLE: begin
                    case (wd)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY:
                            nxt = '{ph: PH_ARG, op: wd};
                        OP_ERASE: begin
                            erase_en  = 1'b1;
                            stat_n[7] = 1'b1;
                            nxt       = '{ph: PH_ARG, op: wd};
                        end
                        OP_BUF: begin
                            stat_n[7] = 1'b1;
                            nxt       = '{ph: PH_ARG, op: wd};
                        end
                        OP_CLR: begin
                            stat_n = 8'h00;
                            nxt    = CTL_ARRAY;
                        end
                        OP_STAT: nxt = '{ph: PH_IDLE, op: wd};
                        default: nxt = CTL_ARRAY;
                    endcase
                end
                PH_ARG: begin
                    case (cur.op)
                        OP_PROG_A, OP_PROG_B: begin
                            prog_en   = 1'b1;
                            stat_n[7] = 1'b1;
                            nxt.ph    = PH_IDLE;
                        end
                        OP_ERASE: begin
                            if (wd == CODE_GO) begin
                                stat_n[7] = 1'b1;
                                nxt.ph    = PH_IDLE;
                            end else begin
                                nxt = CTL_ARRAY;
                            end
                        end
                        OP_LOCK: begin
                            if (wd == CODE_GO || wd == CODE_LOCK) begin
                                stat_n[7] = 1'b1;
                                nxt.ph    = PH_IDLE;
                            end else begin
                                nxt = CTL_ARRAY;
                            end
                        end
                        OP_BUF: begin
                            cnt_n  = CNT_W'(wr_data);
                            nxt.ph = PH_DATA;
                        end
                        OP_QUERY: begin
                            if (wd == OP_ARRAY) nxt = CTL_ARRAY;
                        end
                        default: nxt = CTL_ARRAY;
                    endcase
                end
                PH_DATA: begin
                    prog_en   = 1'b1;
                    stat_n[7] = 1'b1;
                    cnt_n     = cnt - 1'b1;
                    if (cnt == '0) nxt.ph = PH_CONFIRM;
                end
                PH_CONFIRM: begin
                    if (wd == CODE_GO) begin
                        stat_n[7] = 1'b1;
                        nxt.ph    = PH_IDLE;
                    end else begin
                        nxt = CTL_ARRAY;
                    end
                end
                default: nxt = CTL_ARRAY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= CTL_ARRAY;
            cnt    <= '0;
            status <= 8'h00;
        end else begin
            cur    <= nxt;
            cnt    <= cnt_n;
            status <= stat_n;
        end
    end

    always_comb begin
        case (cur.op)
            OP_NONE:  rd_sel = RD_ARRAY;
            OP_QUERY: rd_sel = RD_QUERY;
            default:  rd_sel = RD_STATUS;
        endcase
    end

    a_r3_program_ready: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur.ph == PH_ARG && (cur.op == OP_PROG_A || cur.op == OP_PROG_B))
        |=> (status[7] && rd_sel == RD_STATUS));

    a_r6_clear_status: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur.ph == PH_IDLE && wd == OP_CLR)
        |=> (status == 8'h00 && rd_sel == RD_ARRAY));

    a_r10_unknown_to_array: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur.ph == PH_IDLE && !is_opcode(wd))
        |=> (rd_sel == RD_ARRAY && $stable(status)));

    a_r8_query_sticky: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cur.op == OP_QUERY && cur.ph == PH_ARG && wd != OP_ARRAY)
        |=> rd_sel == RD_QUERY);

    a_r9_confirm_owner: assert property (@(posedge clk) disable iff (rst)
        (cur.ph == PH_CONFIRM || cur.ph == PH_DATA) |-> cur.op == OP_BUF);

endmodule

// File: rtl/nce_top.sv
module nce_top #(
    parameter int ARRAY_BYTES  = 256,
    parameter int SECTOR_BYTES = 64,
    parameter int BUS_BYTES    = 2,
    parameter bit BIG_END      = 1'b0,
    parameter int CNT_W        = 12,
    parameter int QUERY_LEN    = 64,
    localparam int AW = $clog2(ARRAY_BYTES),
    localparam int DW = 8 * BUS_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data
);
    import nce_pkg::*;

    rd_sel_e       rd_sel;
    logic          prog_en, erase_en;
    logic [7:0]    status, qbyte;
    logic [DW-1:0] arr_data;

    nce_seq #(.BUS_BYTES(BUS_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .prog_en(prog_en), .erase_en(erase_en), .status(status)
    );

    nce_array #(.ARRAY_BYTES(ARRAY_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
                .BUS_BYTES(BUS_BYTES), .BIG_END(BIG_END)) u_array (
        .clk(clk), .rst(rst), .addr(addr), .prog_en(prog_en),
        .erase_en(erase_en), .wdata(wr_data), .rdata(arr_data)
    );

    nce_query_rom #(.ARRAY_BYTES(ARRAY_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
                    .BUS_BYTES(BUS_BYTES), .QUERY_LEN(QUERY_LEN)) u_query (
        .raw_idx(8'(addr)), .qbyte(qbyte)
    );

    always_comb begin
        case (rd_sel)
            RD_STATUS: rd_data = DW'(status);
            RD_QUERY:  rd_data = DW'(qbyte);
            default:   rd_data = arr_data;
        endcase
    end

endmodule

// File: tb/tb_nce_top.sv
module tb_nce_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    nce_top dut (.clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
                 .wr_data(wr_data), .rd_data(rd_data));

    // behavioural model
    logic [7:0] mm [256];
    int m_mode;   // 0 array, 1 status, 2 query
    int m_wait;   // 0 idle, 1 argument, 2 data, 3 confirm
    int m_kind;   // pending command byte
    int m_left;
    logic [7:0] m_stat;

    function automatic logic [7:0] qexp(int idx);
        if (idx >= 64) return 8'h00;
        case (idx)
            16'h10: return 8'h51;
            16'h11: return 8'h52;
            16'h12: return 8'h59;
            16'h27: return 8'd8;
            16'h2A: return 8'd11;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] mread(int a);
        if (m_mode == 1) return {8'h00, m_stat};
        if (m_mode == 2) return {8'h00, qexp((a & 255) / 2)};
        return {mm[(a + 1) % 256], mm[a % 256]};
    endfunction

    task automatic mstore(int a, int d);
        mm[a % 256]       = d[7:0];
        mm[(a + 1) % 256] = d[15:8];
    endtask

    task automatic to_array();
        m_mode = 0; m_wait = 0; m_kind = 0;
    endtask

    task automatic mwrite(int a, int d);
        int c = d & 255;
        if (m_wait == 0) begin
            if (c == 'h10 || c == 'h40 || c == 'h60) begin
                m_kind = c; m_wait = 1; m_mode = 1;
            end else if (c == 'h98) begin
                m_kind = c; m_wait = 1; m_mode = 2;
            end else if (c == 'h20) begin
                for (int i = 0; i < 256; i++) if (i / 64 == a / 64) mm[i] = 8'hFF;
                m_stat[7] = 1'b1; m_kind = c; m_wait = 1; m_mode = 1;
            end else if (c == 'hE8) begin
                m_stat[7] = 1'b1; m_kind = c; m_wait = 1; m_mode = 1;
            end else if (c == 'h50) begin
                m_stat = 8'h00; to_array();
            end else if (c == 'h70) begin
                m_kind = c; m_mode = 1;
            end else begin
                to_array();
            end
        end else if (m_wait == 1) begin
            if (m_kind == 'h10 || m_kind == 'h40) begin
                mstore(a, d); m_stat[7] = 1'b1; m_wait = 0;
            end else if (m_kind == 'h20) begin
                if (c == 'hD0) begin m_stat[7] = 1'b1; m_wait = 0; end
                else to_array();
            end else if (m_kind == 'h60) begin
                if (c == 'hD0 || c == 'h01) begin m_stat[7] = 1'b1; m_wait = 0; end
                else to_array();
            end else if (m_kind == 'hE8) begin
                m_left = d; m_wait = 2;
            end else if (m_kind == 'h98) begin
                if (c == 'hFF) to_array();
            end
        end else if (m_wait == 2) begin
            mstore(a, d); m_stat[7] = 1'b1;
            if (m_left == 0) m_wait = 3;
            m_left = m_left - 1;
        end else begin
            if (c == 'hD0) begin m_stat[7] = 1'b1; m_wait = 0; end
            else to_array();
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        addr = 8'(a); wr_data = 16'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        mwrite(a, d);
    endtask

    task automatic chk(string req, int a);
        logic [15:0] exp;
        @(negedge clk);
        addr = 8'(a);
        #1;
        exp = mread(a);
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual=%04h expected=%04h", req, a, rd_data, exp);
        end
    endtask

    task automatic chk_lit(string req, int a, logic [15:0] exp);
        @(negedge clk);
        addr = 8'(a);
        #1;
        n_run++;
        if (rd_data !== exp || mread(a) !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual=%04h expected=%04h", req, a, rd_data, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mm[i] = 8'hFF;
        m_stat = 8'h00; m_left = 0;
        to_array();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk_lit("R1", 8'h00, 16'hFFFF);
        chk("R1", 8'hFE);

        // R3: single program, both codes; R2: byte order
        wr(8'h00, 8'h40); wr(8'h10, 16'h1234);
        chk_lit("R3", 8'h10, 16'h0080);
        wr(8'h00, 8'hFF);
        chk_lit("R2", 8'h10, 16'h1234);
        chk_lit("R2", 8'h11, 16'hFF12);
        wr(8'h00, 8'h10); wr(8'h40, 16'hBEEF);
        wr(8'h00, 8'hFF);
        chk_lit("R3", 8'h40, 16'hBEEF);

        // R5: status read, then next write is a command
        wr(8'h00, 8'h70);
        chk_lit("R5", 8'h40, 16'h0080);
        // R6: clear status
        wr(8'h00, 8'h50);
        chk_lit("R6", 8'h40, 16'hBEEF);
        wr(8'h00, 8'h70);
        chk_lit("R6", 8'h00, 16'h0000);

        // R4: erase with confirm
        wr(8'h12, 8'h20); wr(8'h12, 8'hD0);
        chk_lit("R4", 8'h12, 16'h0080);
        wr(8'h00, 8'hFF);
        chk_lit("R4", 8'h10, 16'hFFFF);
        chk_lit("R4", 8'h40, 16'hBEEF);
        // R4: abort and bad second write
        wr(8'h00, 8'h40); wr(8'h44, 16'h5566);
        wr(8'h44, 8'h20); wr(8'h44, 8'hFF);
        chk_lit("R4", 8'h44, 16'hFFFF);
        wr(8'h00, 8'h40); wr(8'h80, 16'h7788);
        wr(8'h00, 8'h40); wr(8'hC2, 16'h99AA);
        wr(8'hC0, 8'h20); wr(8'hC0, 8'h33);
        chk_lit("R4", 8'h80, 16'h7788);
        chk_lit("R4", 8'hC2, 16'hFFFF);

        // R7: lock/unlock
        wr(8'h00, 8'h50);
        wr(8'h80, 8'h60); wr(8'h80, 8'hD0);
        chk_lit("R7", 8'h80, 16'h0080);
        wr(8'h00, 8'h60); wr(8'h80, 8'h01);
        chk("R7", 8'h80);
        wr(8'h00, 8'h60); wr(8'h80, 8'h22);
        chk_lit("R7", 8'h80, 16'h7788);

        // R8/R11: query mode
        wr(8'h00, 8'h98);
        chk_lit("R8", 8'h20, 16'h0051);
        chk_lit("R8", 8'h22, 16'h0052);
        chk_lit("R8", 8'h24, 16'h0059);
        chk_lit("R8", 8'h90, 16'h0000);
        chk_lit("R11", 8'h54, 16'h000B);
        chk_lit("R11", 8'h4E, 16'h0008);
        wr(8'h00, 8'h55);
        chk_lit("R8", 8'h20, 16'h0051);
        wr(8'h00, 8'hFF);
        chk_lit("R8", 8'h80, 16'h7788);

        // R9: buffered write, N = 2 -> three words
        wr(8'h00, 8'h50);
        wr(8'hA0, 8'hE8); wr(8'hA0, 16'h0002);
        chk_lit("R9", 8'hA0, 16'h0080);
        wr(8'hA0, 16'h1111); wr(8'hA2, 16'h2222); wr(8'hA4, 16'h3333);
        wr(8'hA0, 8'hD0);
        chk_lit("R9", 8'hA0, 16'h0080);
        wr(8'h00, 8'hFF);
        chk_lit("R9", 8'hA0, 16'h1111);
        chk_lit("R9", 8'hA2, 16'h2222);
        chk_lit("R9", 8'hA4, 16'h3333);
        chk_lit("R9", 8'hA6, 16'hFFFF);
        // R9: N = 0 with bad confirm
        wr(8'hB0, 8'hE8); wr(8'hB0, 16'h0000);
        wr(8'hB0, 16'hAAAA); wr(8'hB0, 8'h12);
        chk_lit("R9", 8'hB0, 16'hAAAA);
        chk_lit("R9", 8'hB2, 16'hFFFF);

        // R10: unknown and reset codes at idle
        wr(8'h00, 8'h70);
        wr(8'hB0, 8'h33);
        chk_lit("R10", 8'hB0, 16'hAAAA);
        wr(8'h00, 8'h70);
        chk_lit("R10", 8'h00, 16'h0080);
        wr(8'hB0, 8'h00);
        chk_lit("R10", 8'hB0, 16'hAAAA);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule